// File: doc/BRIEF.md
# Inbound Requester-to-Partition Classifier

This block sorts inbound PCIe requests by isolation group. Every request carries a 16-bit requester ID (bus, device, function). The block folds that ID into an index into a group table, and the entry it finds gives the isolation group for the request. A DMA request also gets a window select, which is address bit 59, to choose between the group's two address windows. An MSI is accepted only if its address falls in one of two MSI windows. One window sits at the top of the 32-bit space and the other at a configurable high location. The address and data are then reduced to an interrupt number, and that interrupt's descriptor must name the same group that the requester-ID lookup produced. If it does not, the MSI is rejected. An error message is tagged with the looked-up group and nothing else.

Both tables are loaded through a simple write port. The classification of each accepted request appears on the outputs exactly one clock after it is presented.

Top module: `rq_part_classifier`

## Requirements
- R1: While `rst_n` is low the outputs clear on each clock edge. Reset sets every requester-table entry to group 0 and marks every interrupt descriptor invalid, so an MSI seen after reset is rejected until a descriptor is written.
- R2: A request presented with `in_valid` high in one cycle produces `out_valid` high in the next cycle, with `out_kind` equal to the presented kind. Without `in_valid`, `out_valid` is low and all result outputs are zero. Kind encoding: 0 = DMA, 1 = MSI, 2 = error message, 3 = reserved.
- R3: `out_grp` is the requester-table entry at index I, where I is the XOR of the RID's 16 bits folded modulo RID_IDX_W (RID bit k goes to index bit k mod RID_IDX_W). This holds for every kind.
- R4: For DMA, `out_win` equals address bit 59 and `out_reject` is 0. For every other kind, `out_win` is 0.
- R5: An MSI address hits the low window when bits 63:16 equal 0x0000_0000_FFFF and bits 1:0 are zero.
- R6: An MSI address hits the high window when bits 63:16 equal the parameter MSI_HI_TAG and bits 1:0 are zero.
- R7: The interrupt number is the source vector {address bits 15:2, in_data} XOR-folded to IRQ_W bits (source bit k goes to bit k mod IRQ_W).
- R8: A window-hitting MSI raises `out_irq_valid` and drives the interrupt number on `out_irq` only if that interrupt's descriptor is valid and its group equals `out_grp`. Otherwise it raises `out_reject` and keeps `out_irq_valid` and `out_irq` at zero. `out_irq_valid` and `out_reject` are never high together.
- R9: An MSI outside both windows is rejected.
- R10: An error message is never rejected and never raises `out_irq_valid`.
- R11: With `cfg_we` high, `cfg_sel` = 0 writes `cfg_wdata[GRP_W-1:0]` into requester-table entry `cfg_idx`. `cfg_sel` = 1 writes descriptor `cfg_idx` with valid bit `cfg_wdata[GRP_W]` and group `cfg_wdata[GRP_W-1:0]`. A write to an index beyond the table's depth is ignored. A request presented in the same cycle as a write still sees the old contents.
- R12: A request of the reserved kind is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 2 | Request kind (0 DMA, 1 MSI, 2 error, 3 reserved) |
| in_rid | input | 16 | Requester ID |
| in_addr | input | 64 | Request address |
| in_data | input | MSI_DATA_W | MSI data payload |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 = requester table, 1 = descriptor table |
| cfg_idx | input | max(RID_IDX_W, IRQ_W) | Entry index |
| cfg_wdata | input | GRP_W+1 | Descriptor valid bit on top, group below |
| out_valid | output | 1 | Result present |
| out_kind | output | 2 | Kind of the classified request |
| out_grp | output | GRP_W | Isolation group from the requester lookup |
| out_win | output | 1 | DMA window select |
| out_irq_valid | output | 1 | Authorized MSI |
| out_irq | output | IRQ_W | Interrupt number of an authorized MSI |
| out_reject | output | 1 | Request refused |

## Verification
The bench builds the block with RID_IDX_W = 4, IRQ_W = 6, GRP_W = 5 and MSI_DATA_W = 8. With a 16-entry requester table, many different IDs fold onto the same entry, and a 64-entry descriptor table lets random writes revisit descriptors often enough that both matching and mismatching groups occur. A 6-bit configuration index is wider than the requester table, so writes beyond that table's depth are exercised. Random write traffic runs alongside the requests, which covers the case where a write and a lookup fall in the same cycle.

// File: rtl/cls_pkg.sv
// Shared definitions for the requester-to-partition classifier.
// Assumes: the kind encoding is fixed across all users of the block.
package cls_pkg;

    typedef enum logic [1:0] {
        KIND_DMA  = 2'd0,
        KIND_MSI  = 2'd1,
        KIND_ERR  = 2'd2,
        KIND_RSVD = 2'd3
    } req_kind_e;

    // Address bits 63:16 that mark the MSI window at the top of 32-bit space.
    localparam logic [47:0] MSI_LO_TAG = 48'h0000_0000_FFFF;

    // Address bit that picks one of the two DMA windows.
    localparam int DMA_WIN_BIT = 59;

endpackage

// File: rtl/rid_group_table.sv
// Requester table: folds a 16-bit requester ID into an index and returns
// the stored group number. Written through a simple write port.
// Assumes: IDX_W <= 16 and CFG_W >= IDX_W. Writes past the depth are dropped.
module rid_group_table #(
    parameter int IDX_W = 8,
    parameter int GRP_W = 8,
    parameter int CFG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_idx,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [15:0]      rid,
    output logic [GRP_W-1:0] grp
);
    localparam int DEPTH = 1 << IDX_W;

    logic [GRP_W-1:0] tab_q [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic             wr_in_range;

    // Decide whether a write index lies inside the table.
    generate
        if (CFG_W > IDX_W) begin : g_range_chk
            assign wr_in_range = (wr_idx[CFG_W-1:IDX_W] == '0);
        end else begin : g_range_full
            assign wr_in_range = 1'b1;
        end
    endgenerate

    // XOR-fold the requester ID down to a table index.
    always_comb begin
        rd_idx = '0;
        for (int i = 0; i < 16; i++) begin
            rd_idx[i % IDX_W] = rd_idx[i % IDX_W] ^ rid[i];
        end
    end

    // Hold the table; reset every entry to group 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tab_q[i] <= '0;
            end
        end else if (wr_en && wr_in_range) begin
            tab_q[wr_idx[IDX_W-1:0]] <= wr_grp;
        end
    end

    assign grp = tab_q[rd_idx];

endmodule

// File: rtl/msi_window_decoder.sv
// Recognises MSI addresses in the low and high windows and folds the
// address and data into an interrupt number.
// Assumes: MSI writes are dword aligned; a misaligned address misses.
module msi_window_decoder
    import cls_pkg::*;
#(
    parameter int          IRQ_W      = 11,
    parameter int          MSI_DATA_W = 16,
    parameter logic [47:0] HI_TAG     = 48'h0003_FFFF_0000
) (
    input  logic [63:0]           addr,
    input  logic [MSI_DATA_W-1:0] data,
    output logic                  hit,
    output logic [IRQ_W-1:0]      irq
);
    localparam int SRC_W = 14 + MSI_DATA_W;
    localparam int N_WIN = 2;

    logic [SRC_W-1:0] src;
    logic [N_WIN-1:0] win_hit;
    logic             aligned;

    assign aligned = (addr[1:0] == 2'b00);

    // One comparator per window; the tags come from the package and a parameter.
    generate
        for (genvar w = 0; w < N_WIN; w++) begin : g_win
            localparam logic [47:0] TAG = (w == 0) ? MSI_LO_TAG : HI_TAG;
            assign win_hit[w] = (addr[63:16] == TAG);
        end
    endgenerate

    assign hit = aligned && (win_hit != '0);
    assign src = {addr[15:2], data};

    // Fold the source vector down to the interrupt number width.
    always_comb begin
        irq = '0;
        for (int i = 0; i < SRC_W; i++) begin
            irq[i % IRQ_W] = irq[i % IRQ_W] ^ src[i];
        end
    end

endmodule

// File: rtl/irq_desc_table.sv
// Interrupt descriptor table: per-interrupt valid flag and owner group.
// Assumes: CFG_W >= IRQ_W. Writes past the depth are dropped. Reset invalidates all entries.
module irq_desc_table #(
    parameter int IRQ_W = 11,
    parameter int GRP_W = 8,
    parameter int CFG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [IRQ_W-1:0] rd_irq,
    output logic             rd_valid,
    output logic [GRP_W-1:0] rd_grp
);
    localparam int DEPTH = 1 << IRQ_W;

    logic             vld_q [DEPTH];
    logic [GRP_W-1:0] own_q [DEPTH];
    logic             wr_in_range;

    // Decide whether a write index lies inside the table.
    generate
        if (CFG_W > IRQ_W) begin : g_range_chk
            assign wr_in_range = (wr_idx[CFG_W-1:IRQ_W] == '0);
        end else begin : g_range_full
            assign wr_in_range = 1'b1;
        end
    endgenerate

    // Hold descriptors; reset clears valid and owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                own_q[i] <= '0;
            end
        end else if (wr_en && wr_in_range) begin
            vld_q[wr_idx[IRQ_W-1:0]] <= wr_valid;
            own_q[wr_idx[IRQ_W-1:0]] <= wr_grp;
        end
    end

    assign rd_valid = vld_q[rd_irq];
    assign rd_grp   = own_q[rd_irq];

endmodule

// File: rtl/rq_part_classifier.sv
// Classifies inbound DMA, MSI and error-message requests by isolation group.
// The result is registered one cycle after the request. MSIs need a window
// hit and a descriptor owned by the requester's group.
// Assumes: GRP_W <= 15. Table writes land on the clock edge, after the
// same-cycle lookup has used the old contents.
module rq_part_classifier
    import cls_pkg::*;
#(
    parameter int          GRP_W      = 8,
    parameter int          RID_IDX_W  = 8,
    parameter int          IRQ_W      = 11,
    parameter int          MSI_DATA_W = 16,
    parameter logic [47:0] MSI_HI_TAG = 48'h0003_FFFF_0000
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             in_valid,
    input  logic [1:0]                                       in_kind,
    input  logic [15:0]                                      in_rid,
    input  logic [63:0]                                      in_addr,
    input  logic [MSI_DATA_W-1:0]                            in_data,
    input  logic                                             cfg_we,
    input  logic                                             cfg_sel,
    input  logic [((RID_IDX_W > IRQ_W) ? RID_IDX_W : IRQ_W)-1:0] cfg_idx,
    input  logic [GRP_W:0]                                   cfg_wdata,
    output logic                                             out_valid,
    output logic [1:0]                                       out_kind,
    output logic [GRP_W-1:0]                                 out_grp,
    output logic                                             out_win,
    output logic                                             out_irq_valid,
    output logic [IRQ_W-1:0]                                 out_irq,
    output logic                                             out_reject
);
    localparam int CFG_W = (RID_IDX_W > IRQ_W) ? RID_IDX_W : IRQ_W;

    logic [GRP_W-1:0] rid_grp;
    logic             msi_hit;
    logic [IRQ_W-1:0] msi_irq;
    logic             dsc_valid;
    logic [GRP_W-1:0] dsc_grp;
    req_kind_e        kind;

    logic             nx_win;
    logic             nx_irq_valid;
    logic [IRQ_W-1:0] nx_irq;
    logic             nx_reject;

    rid_group_table #(
        .IDX_W (RID_IDX_W),
        .GRP_W (GRP_W),
        .CFG_W (CFG_W)
    ) rid_tab_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we && !cfg_sel),
        .wr_idx (cfg_idx),
        .wr_grp (cfg_wdata[GRP_W-1:0]),
        .rid    (in_rid),
        .grp    (rid_grp)
    );

    msi_window_decoder #(
        .IRQ_W      (IRQ_W),
        .MSI_DATA_W (MSI_DATA_W),
        .HI_TAG     (MSI_HI_TAG)
    ) msi_dec_i (
        .addr (in_addr),
        .data (in_data),
        .hit  (msi_hit),
        .irq  (msi_irq)
    );

    irq_desc_table #(
        .IRQ_W (IRQ_W),
        .GRP_W (GRP_W),
        .CFG_W (CFG_W)
    ) dsc_tab_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && cfg_sel),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_wdata[GRP_W]),
        .wr_grp   (cfg_wdata[GRP_W-1:0]),
        .rd_irq   (msi_irq),
        .rd_valid (dsc_valid),
        .rd_grp   (dsc_grp)
    );

    assign kind = req_kind_e'(in_kind);

    // Work out the per-kind result fields for the current request.
    always_comb begin
        nx_win       = 1'b0;
        nx_irq_valid = 1'b0;
        nx_irq       = '0;
        nx_reject    = 1'b0;
        case (kind)
            KIND_DMA: nx_win = in_addr[DMA_WIN_BIT];
            KIND_MSI: begin
                if (msi_hit && dsc_valid && (dsc_grp == rid_grp)) begin
                    nx_irq_valid = 1'b1;
                    nx_irq       = msi_irq;
                end else begin
                    nx_reject = 1'b1;
                end
            end
            KIND_ERR:  nx_reject = 1'b0;
            default:   nx_reject = 1'b1;
        endcase
    end

    // Register the classification; clear the outputs when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid     <= 1'b0;
            out_kind      <= 2'd0;
            out_grp       <= '0;
            out_win       <= 1'b0;
            out_irq_valid <= 1'b0;
            out_irq       <= '0;
            out_reject    <= 1'b0;
        end else begin
            out_valid     <= 1'b1;
            out_kind      <= in_kind;
            out_grp       <= rid_grp;
            out_win       <= nx_win;
            out_irq_valid <= nx_irq_valid;
            out_irq       <= nx_irq;
            out_reject    <= nx_reject;
        end
    end

endmodule

// File: rtl/cls_checker.sv
// Temporal checks on the classifier's ports, attached to every instance by bind.
// Assumes: the kind encoding from cls_pkg.
module cls_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_kind,
    input logic       dma_sel_bit,
    input logic       out_valid,
    input logic [1:0] out_kind,
    input logic       out_win,
    input logic       out_irq_valid,
    input logic       out_reject
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_kind == $past(in_kind)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_reject && !out_irq_valid));

    p_dma_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd0) |=> (out_win == $past(dma_sel_bit) && !out_reject));

    p_win_only_dma_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'd0) |-> !out_win);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_irq_valid && out_reject));

    p_irq_is_msi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq_valid |-> (out_valid && out_kind == 2'd1));

    p_err_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd2) |-> (!out_reject && !out_irq_valid));

    p_rsvd_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd3) |-> out_reject);

endmodule

bind rq_part_classifier cls_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_kind       (in_kind),
    .dma_sel_bit   (in_addr[59]),
    .out_valid     (out_valid),
    .out_kind      (out_kind),
    .out_win       (out_win),
    .out_irq_valid (out_irq_valid),
    .out_reject    (out_reject)
);

// File: tb/rq_part_classifier_tb_top.sv
// Bench: a behavioural model predicts every output on each clock edge.
module rq_part_classifier_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          GRP_W      = 5;
    localparam int          RID_IDX_W  = 4;
    localparam int          IRQ_W      = 6;
    localparam int          MSI_DATA_W = 8;
    localparam int          CFG_W      = 6;
    localparam logic [47:0] HI_TAG     = 48'h0003_FFFF_0000;
    localparam int          RID_DEPTH  = 16;
    localparam int          IRQ_DEPTH  = 64;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [1:0]            in_kind = '0;
    logic [15:0]           in_rid = '0;
    logic [63:0]           in_addr = '0;
    logic [MSI_DATA_W-1:0] in_data = '0;
    logic                  cfg_we = 1'b0;
    logic                  cfg_sel = 1'b0;
    logic [CFG_W-1:0]      cfg_idx = '0;
    logic [GRP_W:0]        cfg_wdata = '0;
    logic                  out_valid;
    logic [1:0]            out_kind;
    logic [GRP_W-1:0]      out_grp;
    logic                  out_win;
    logic                  out_irq_valid;
    logic [IRQ_W-1:0]      out_irq;
    logic                  out_reject;

    rq_part_classifier #(
        .GRP_W(GRP_W), .RID_IDX_W(RID_IDX_W), .IRQ_W(IRQ_W),
        .MSI_DATA_W(MSI_DATA_W), .MSI_HI_TAG(HI_TAG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_rid(in_rid), .in_addr(in_addr), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_kind(out_kind), .out_grp(out_grp),
        .out_win(out_win), .out_irq_valid(out_irq_valid), .out_irq(out_irq),
        .out_reject(out_reject)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    int rid_tab [RID_DEPTH];
    bit dsc_v   [IRQ_DEPTH];
    int dsc_g   [IRQ_DEPTH];

    int e_valid, e_kind, e_grp, e_win, e_irqv, e_irq, e_rej;

    function automatic int fold_rid(input logic [15:0] r);
        int x = 0;
        for (int i = 0; i < 16; i++) if (r[i]) x = x ^ (1 << (i % RID_IDX_W));
        return x;
    endfunction

    function automatic int irq_of(input logic [63:0] a, input logic [MSI_DATA_W-1:0] d);
        logic [13+MSI_DATA_W:0] s = {a[15:2], d};
        int x = 0;
        for (int i = 0; i < 14 + MSI_DATA_W; i++) if (s[i]) x = x ^ (1 << (i % IRQ_W));
        return x;
    endfunction

    function automatic bit in_msi_win(input logic [63:0] a);
        return (a[1:0] == 2'b00) && (a[63:16] == 48'h0000_0000_FFFF || a[63:16] == HI_TAG);
    endfunction

    // Reference model: predict outputs from the inputs and the model tables, then apply writes.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            {e_valid, e_kind, e_grp, e_win, e_irqv, e_irq, e_rej} = '0;
            for (int i = 0; i < RID_DEPTH; i++) rid_tab[i] = 0;
            for (int i = 0; i < IRQ_DEPTH; i++) begin dsc_v[i] = 0; dsc_g[i] = 0; end
        end else begin
            {e_valid, e_kind, e_grp, e_win, e_irqv, e_irq, e_rej} = '0;
            if (in_valid) begin
                int q;
                e_valid = 1;
                e_kind  = in_kind;
                e_grp   = rid_tab[fold_rid(in_rid)];
                q       = irq_of(in_addr, in_data);
                case (in_kind)
                    2'd0: e_win = in_addr[59];
                    2'd1: if (in_msi_win(in_addr) && dsc_v[q] && dsc_g[q] == e_grp) begin
                              e_irqv = 1; e_irq = q;
                          end else e_rej = 1;
                    2'd2: ;
                    default: e_rej = 1;
                endcase
            end
            if (cfg_we) begin
                if (!cfg_sel && cfg_idx < RID_DEPTH) rid_tab[cfg_idx] = cfg_wdata[GRP_W-1:0];
                if (cfg_sel) begin
                    dsc_v[cfg_idx] = cfg_wdata[GRP_W];
                    dsc_g[cfg_idx] = cfg_wdata[GRP_W-1:0];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            string rq;
            case (e_kind)
                0: rq = "R4";
                1: rq = "R5/R6/R8/R9";
                2: rq = "R10";
                default: rq = "R12";
            endcase
            chk(out_valid == e_valid, "R2", "out_valid", out_valid, e_valid);
            chk(out_kind == e_kind, "R2", "out_kind", out_kind, e_kind);
            chk(out_grp == e_grp, "R3/R11", "out_grp", out_grp, e_grp);
            chk(out_win == e_win, "R4", "out_win", out_win, e_win);
            chk(out_irq_valid == e_irqv, rq, "out_irq_valid", out_irq_valid, e_irqv);
            chk(out_irq == e_irq, "R7", "out_irq", out_irq, e_irq);
            chk(out_reject == e_rej, rq, "out_reject", out_reject, e_rej);
        end
    end

    task automatic send(input int k, input logic [15:0] r, input logic [63:0] a, input logic [MSI_DATA_W-1:0] d);
        @(negedge clk);
        in_valid = 1; in_kind = k[1:0]; in_rid = r; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic cfg(input bit s, input int idx, input int wd);
        @(negedge clk);
        cfg_we = 1; cfg_sel = s; cfg_idx = idx[CFG_W-1:0]; cfg_wdata = wd[GRP_W:0];
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [63:0] LO_MSI = 64'h0000_0000_FFFF_0010;
    localparam logic [63:0] HI_MSI = 64'h0003_FFFF_0000_0010;

    initial begin
        int q;
        repeat (3) @(negedge clk);
        // R1: outputs idle while in reset
        chk(out_valid == 0 && out_reject == 0 && out_irq_valid == 0, "R1", "reset outputs",
            {out_valid, out_reject, out_irq_valid}, 0);
        rst_n = 1;
        // R1: descriptors invalid after reset, MSI rejected; group 0
        send(1, 16'h0005, LO_MSI, 8'h02);
        @(negedge clk);
        chk(out_valid == 0, "R1", "idle after request", out_valid, 0);
        send(0, 16'h0005, 64'h0800_0000_0000_1000, 8'h00);
        // R11: program requester groups and one descriptor
        cfg(0, fold_rid(16'h0005), 7);
        cfg(0, fold_rid(16'h1234), 3);
        cfg(0, fold_rid(16'h0009), 31);
        q = irq_of(LO_MSI, 8'h02);
        cfg(1, q, 32 | 7);
        // R8 authorized low window (R5), high window (R6)
        send(1, 16'h0005, LO_MSI, 8'h02);
        send(1, 16'h0005, HI_MSI, 8'h02);
        // R8 mismatch
        send(1, 16'h1234, LO_MSI, 8'h02);
        // R9 outside windows and misaligned
        send(1, 16'h0005, 64'h0000_0001_FFFF_0010, 8'h02);
        send(1, 16'h0005, LO_MSI | 64'h1, 8'h02);
        // R4 both DMA windows
        send(0, 16'h0009, 64'h0800_0000_0000_0000, 8'h00);
        send(0, 16'h0009, 64'h0000_0000_0000_0000, 8'h00);
        // R10 and R12
        send(2, 16'h1234, LO_MSI, 8'h02);
        send(3, 16'h0009, 64'h0, 8'h00);
        // R11 out-of-range requester write is ignored
        cfg(0, 16 + fold_rid(16'h0005), 1);
        send(2, 16'h0005, 64'h0, 8'h00);
        // Random traffic with concurrent table writes
        for (int n = 0; n < 600; n++) begin
            int sel;
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            in_kind  = 2'($urandom % 4);
            sel = $urandom % 4;
            in_rid = (sel == 0) ? 16'h0005 : (sel == 1) ? 16'h1234 : 16'($urandom);
            sel = $urandom % 5;
            case (sel)
                0: in_addr = {48'h0000_0000_FFFF, 16'($urandom) & 16'hFFFC};
                1: in_addr = {HI_TAG, 16'($urandom) & 16'hFFFC};
                2: in_addr = {48'h0000_0000_FFFF, 16'($urandom) | 16'h0001};
                default: in_addr = {32'($urandom), 32'($urandom)};
            endcase
            in_data = MSI_DATA_W'($urandom);
            cfg_we = ($urandom % 3) == 0;
            cfg_sel = $urandom % 2;
            cfg_idx = CFG_W'($urandom);
            cfg_wdata = {1'($urandom), GRP_W'($urandom % 4)};
        end
        @(negedge clk);
        in_valid = 0; cfg_we = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule